// File: doc/BRIEF.md
# SD Command Issue Engine

This block sends one SD-card command at a time on a single-bit command line and collects the card's reply. A request gives a 6-bit command index, a 32-bit argument with an argument-valid qualifier, a response-expected flag and a long-response flag. A start strobe launches the request. The engine serializes a 48-bit frame with its CRC7 and sends one bit per clock, most significant bit first. It then either finishes at once or waits a bounded number of cycles for the card's start bit. It shifts in a 48-bit or 136-bit reply and presents the payload on four 32-bit words.

Completion is reported through four sticky flags: done, timeout, response valid and CRC error. Each flag is cleared by writing a one to its bit of the clear input. Accepting a new command clears all four flags. A busy output covers the whole transaction, and a new start is accepted only while busy is low. The clock driving the block is taken to be the command-line bit clock. Reset is asserted asynchronously and released on the clock through a two-stage synchronizer.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset busy, the line enable and all four flags are 0, the line output is 1 and all response words are 0.
- R2: An accepted command is driven on the following 48 cycles, MSB first, with the line enable high throughout. The frame is: bit 47 = 0, bit 46 = 1, bits 45:40 = index, bits 39:8 = argument, bits 7:1 = CRC7 (x^7+x^3+1, register starting at zero) over bits 47:8, and bit 0 = 1. When the enable is low the line output is 1.
- R3: When the argument-valid input is 0, frame bits 39:8 are zero whatever the argument input holds.
- R4: For a command with no response expected, the done flag is set and busy falls on the clock edge that ends the last frame bit. The response-valid flag stays 0.
- R5: With a response expected, the line is sampled from the edge after the frame ends. If it stays high for 64 consecutive edges, the timeout flag is set and busy falls on that 64th edge. A start bit (0) on the 64th edge is still accepted as a response.
- R6: A short response is 48 bits starting with the start bit. Its bits 39:8 appear on rsp_word0, and words 1 to 3 read 0. The done and response-valid flags are set on the edge that samples the last bit.
- R7: A long response is 136 bits, and its last 128 bits are presented in reversed word order: rsp_word0 holds bits 127:96 (received first) and rsp_word3 holds bits 31:0.
- R8: A short response whose bits 7:1 differ from the CRC7 of its bits 47:8 sets the CRC-error flag together with response valid. Long responses never set the CRC-error flag.
- R9: The long-response input has no effect unless response-expected is also 1. Such a command completes as a no-response command and leaves the response words unchanged.
- R10: A start strobe while busy is ignored. The frame in flight is not altered.
- R11: Flag clear bits are {crc_err, rsp_valid, timeout, done} = flag_clear[3:0], and each is write-one-to-clear. A set event in the same cycle as a clear of that flag wins. All flags read 0 from the edge that accepts a command.
- R12: Busy is 1 from the edge that accepts a start until the completion edge of R4, R5 or R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command-line bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe, honoured only when idle |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| arg_valid | input | 1 | Argument is sent only when 1 |
| rsp_expect | input | 1 | A response is awaited |
| rsp_long | input | 1 | Response is the 136-bit form |
| flag_clear | input | 4 | Write-one-to-clear of {crc_err, rsp_valid, timeout, done} |
| cmd_line_in | input | 1 | Sampled command line from the card |
| cmd_line_out | output | 1 | Command line value driven |
| cmd_line_oe | output | 1 | Command line drive enable |
| busy | output | 1 | Transaction in progress |
| flag_done | output | 1 | Sticky: command completed |
| flag_timeout | output | 1 | Sticky: no response within 64 cycles |
| flag_rsp_valid | output | 1 | Sticky: response captured |
| flag_crc_err | output | 1 | Sticky: short response CRC mismatch |
| rsp_word0 | output | 32 | Short status or long bits 127:96 |
| rsp_word1 | output | 32 | Long bits 95:64 |
| rsp_word2 | output | 32 | Long bits 63:32 |
| rsp_word3 | output | 32 | Long bits 31:0 |

## Verification
Two functions meet in one cycle: a write-one-to-clear of the flags and the completion edge that sets them. The bench holds all four clear bits high only on the cycle in which the last response bit is sampled, then expects the flags set afterwards. A second coincidence is a start strobe that arrives mid-frame. It is judged by checking that every remaining frame bit still matches the command already in flight. The 64-cycle window is probed from both sides: a start bit on the 64th waiting edge is still accepted, and a line that stays high for that edge times out.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int CMD_FRAME_BITS = 48;
  localparam int SHORT_RSP_BITS = 48;
  localparam int LONG_RSP_BITS  = 136;
  localparam int KEEP_BITS      = 128;
  localparam int NUM_FLAGS      = 4;
  localparam int FLG_DONE       = 0;
  localparam int FLG_TMO        = 1;
  localparam int FLG_RSP        = 2;
  localparam int FLG_CRC        = 3;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_WAIT = 2'd1,
    RX_RECV = 2'd2
  } rx_state_e;

  // Serial CRC7, polynomial x^7 + x^3 + 1, MSB of the input first.
  function automatic logic [6:0] crc7_calc(input logic [39:0] bits);
    logic [6:0] c;
    logic       fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = bits[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction
endpackage

// File: rtl/sdc_cmd_tx.sv
module sdc_cmd_tx
  import sdc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [5:0]  idx,
  input  logic [31:0] arg,
  output logic        line_out,
  output logic        line_oe,
  output logic        last_bit
);
  localparam int CW = $clog2(CMD_FRAME_BITS);

  logic [CMD_FRAME_BITS-1:0] sh_q, sh_d;
  logic [CW-1:0]             cnt_q, cnt_d;
  logic                      act_q, act_d;
  logic [39:0]               head;
  logic [CMD_FRAME_BITS-1:0] frame;

  assign head  = {1'b0, 1'b1, idx, arg};
  assign frame = {head, crc7_calc(head), 1'b1};

  assign last_bit = act_q && (cnt_q == CW'(CMD_FRAME_BITS - 1));
  assign line_oe  = act_q;
  assign line_out = act_q ? sh_q[CMD_FRAME_BITS-1] : 1'b1;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    act_d = act_q;
    if (load) begin
      sh_d  = frame;
      cnt_d = '0;
      act_d = 1'b1;
    end else if (act_q) begin
      sh_d  = {sh_q[CMD_FRAME_BITS-2:0], 1'b1};
      cnt_d = cnt_q + 1'b1;
      if (last_bit) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/sdc_rsp_rx.sv
module sdc_rsp_rx
  import sdc_pkg::*;
#(
  parameter int TMO_CYCLES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm,
  input  logic                 long_mode,
  input  logic                 line_in,
  output logic                 active,
  output logic                 finish,
  output logic                 timed_out,
  output logic                 crc_bad,
  output logic [KEEP_BITS-1:0] words
);
  localparam int TW = (TMO_CYCLES > 1) ? $clog2(TMO_CYCLES) : 1;
  localparam int RW = $clog2(LONG_RSP_BITS);

  rx_state_e              st_q, st_d;
  logic [TW-1:0]          tcnt_q, tcnt_d;
  logic [RW-1:0]          rcnt_q, rcnt_d;
  logic [KEEP_BITS-2:0]   sh_q, sh_d;
  logic                   long_q, long_d;
  logic [KEEP_BITS-1:0]   words_q, words_d;
  logic [KEEP_BITS-1:0]   nxt;
  logic [RW-1:0]          last_idx;

  assign nxt      = {sh_q, line_in};
  assign last_idx = long_q ? RW'(LONG_RSP_BITS - 1) : RW'(SHORT_RSP_BITS - 1);
  assign active   = (st_q != RX_IDLE);
  assign finish   = (st_q == RX_RECV) && (rcnt_q == last_idx);
  assign timed_out = (st_q == RX_WAIT) && line_in && (tcnt_q == TW'(TMO_CYCLES - 1));
  assign crc_bad  = finish && !long_q && (crc7_calc(nxt[47:8]) != nxt[7:1]);
  assign words    = words_q;

  always_comb begin
    st_d    = st_q;
    tcnt_d  = tcnt_q;
    rcnt_d  = rcnt_q;
    sh_d    = sh_q;
    long_d  = long_q;
    words_d = words_q;
    case (st_q)
      RX_IDLE: begin
        if (arm) begin
          st_d   = RX_WAIT;
          tcnt_d = '0;
          long_d = long_mode;
        end
      end
      RX_WAIT: begin
        if (!line_in) begin
          st_d   = RX_RECV;
          rcnt_d = RW'(1);
          sh_d   = nxt[KEEP_BITS-2:0];
        end else if (timed_out) begin
          st_d = RX_IDLE;
        end else begin
          tcnt_d = tcnt_q + 1'b1;
        end
      end
      RX_RECV: begin
        sh_d   = nxt[KEEP_BITS-2:0];
        rcnt_d = rcnt_q + 1'b1;
        if (finish) begin
          st_d = RX_IDLE;
          if (long_q) words_d = nxt;
          else        words_d = {nxt[39:8], 96'd0};
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      tcnt_q  <= '0;
      rcnt_q  <= '0;
      sh_q    <= '1;
      long_q  <= 1'b0;
      words_q <= '0;
    end else begin
      st_q    <= st_d;
      tcnt_q  <= tcnt_d;
      rcnt_q  <= rcnt_d;
      sh_q    <= sh_d;
      long_q  <= long_d;
      words_q <= words_d;
    end
  end
endmodule

// File: rtl/sdc_flags.sv
module sdc_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wipe,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic f_q, f_d;
    always_comb begin
      if (wipe) f_d = 1'b0;
      else      f_d = (f_q & ~clr[g]) | set[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f_q <= 1'b0;
      else        f_q <= f_d;
    end
    assign flags[g] = f_q;
  end
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sdc_pkg::*;
#(
  parameter int TMO_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  cmd_index,
  input  logic [31:0] cmd_arg,
  input  logic        arg_valid,
  input  logic        rsp_expect,
  input  logic        rsp_long,
  input  logic [3:0]  flag_clear,
  input  logic        cmd_line_in,
  output logic        cmd_line_out,
  output logic        cmd_line_oe,
  output logic        busy,
  output logic        flag_done,
  output logic        flag_timeout,
  output logic        flag_rsp_valid,
  output logic        flag_crc_err,
  output logic [31:0] rsp_word0,
  output logic [31:0] rsp_word1,
  output logic [31:0] rsp_word2,
  output logic [31:0] rsp_word3
);
  logic [1:0]           rs_q;
  logic                 rst_i_n;
  logic                 accept;
  logic                 rsp_q, rsp_d, long_q, long_d;
  logic                 tx_last, arm;
  logic                 rx_active, rx_fin, rx_tmo, rx_crc_bad;
  logic [KEEP_BITS-1:0] words;
  logic [NUM_FLAGS-1:0] set_v, flg;

  // reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  assign accept = start && !busy;
  assign arm    = tx_last && rsp_q;
  assign busy   = cmd_line_oe || rx_active;

  always_comb begin
    rsp_d  = rsp_q;
    long_d = long_q;
    if (accept) begin
      rsp_d  = rsp_expect;
      long_d = rsp_expect && rsp_long;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rsp_q  <= 1'b0;
      long_q <= 1'b0;
    end else begin
      rsp_q  <= rsp_d;
      long_q <= long_d;
    end
  end

  sdc_cmd_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (accept),
    .idx      (cmd_index),
    .arg      (arg_valid ? cmd_arg : 32'd0),
    .line_out (cmd_line_out),
    .line_oe  (cmd_line_oe),
    .last_bit (tx_last)
  );

  sdc_rsp_rx #(.TMO_CYCLES(TMO_CYCLES)) u_rx (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .arm       (arm),
    .long_mode (long_q),
    .line_in   (cmd_line_in),
    .active    (rx_active),
    .finish    (rx_fin),
    .timed_out (rx_tmo),
    .crc_bad   (rx_crc_bad),
    .words     (words)
  );

  always_comb begin
    set_v           = '0;
    set_v[FLG_DONE] = (tx_last && !rsp_q) || rx_fin;
    set_v[FLG_TMO]  = rx_tmo;
    set_v[FLG_RSP]  = rx_fin;
    set_v[FLG_CRC]  = rx_crc_bad;
  end

  sdc_flags #(.N(NUM_FLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_i_n),
    .wipe  (accept),
    .set   (set_v),
    .clr   (flag_clear),
    .flags (flg)
  );

  assign flag_done      = flg[FLG_DONE];
  assign flag_timeout   = flg[FLG_TMO];
  assign flag_rsp_valid = flg[FLG_RSP];
  assign flag_crc_err   = flg[FLG_CRC];
  assign rsp_word0      = words[127:96];
  assign rsp_word1      = words[95:64];
  assign rsp_word2      = words[63:32];
  assign rsp_word3      = words[31:0];
endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        cmd_line_out,
  input logic        cmd_line_oe,
  input logic        busy,
  input logic        flag_done,
  input logic        flag_timeout,
  input logic        flag_rsp_valid,
  input logic        flag_crc_err
);
  assert_oe_in_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_line_oe |-> busy);

  assert_idle_line_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_line_oe |-> cmd_line_out);

  assert_done_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_done) |-> !busy);

  assert_tmo_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_timeout) |-> (!flag_done && !flag_rsp_valid && !busy));

  assert_crc_with_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_crc_err) |-> flag_rsp_valid);

  assert_start_wipes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (!flag_done && !flag_timeout && !flag_rsp_valid && !flag_crc_err && busy));
endmodule

bind sd_cmd_engine sd_cmd_engine_chk u_chk (.*);

// File: tb/sim_sd_cmd_engine.sv
`timescale 1ns/1ps
module sim_sd_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [5:0]  cmd_index;
  logic [31:0] cmd_arg;
  logic        arg_valid, rsp_expect, rsp_long;
  logic [3:0]  flag_clear;
  logic        cmd_line_in;
  logic        cmd_line_out, cmd_line_oe, busy;
  logic        flag_done, flag_timeout, flag_rsp_valid, flag_crc_err;
  logic [31:0] rsp_word0, rsp_word1, rsp_word2, rsp_word3;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  sd_cmd_engine u0 (.*);

  function automatic logic [6:0] ref_crc(input logic [39:0] v);
    logic [46:0] r;
    r = {v, 7'd0};
    for (int i = 46; i >= 7; i--)
      if (r[i]) r = r ^ (47'h89 << (i - 7));
    return r[6:0];
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [3:0] flags_now();
    return {flag_crc_err, flag_rsp_valid, flag_timeout, flag_done};
  endfunction

  // Launch a command and follow its frame bit by bit.
  task automatic issue(input logic [5:0] idx, input logic [31:0] arg,
                       input logic aen, input logic ren, input logic rlong,
                       output logic [47:0] fr);
    logic [31:0] a;
    a  = aen ? arg : 32'd0;
    fr = {2'b01, idx, a, ref_crc({2'b01, idx, a}), 1'b1};
    cmd_index = idx; cmd_arg = arg; arg_valid = aen;
    rsp_expect = ren; rsp_long = rlong; start = 1'b1;
    tick();
    start = 1'b0;
    chk("R12 busy after accept", busy, 1);
    chk("R11 flags wiped by start", flags_now(), 0);
    for (int k = 0; k < 48; k++) begin
      chk("R2 line enable", cmd_line_oe, 1);
      chk("R2 frame bit", cmd_line_out, fr[47-k]);
      chk("R12 busy in frame", busy, 1);
      if (k == 10) begin start = 1'b1; cmd_index = ~idx; cmd_arg = ~arg; end  // R10
      if (k == 11) start = 1'b0;
      tick();
    end
    chk("R2 enable released", cmd_line_oe, 0);
    chk("R2 idle line high", cmd_line_out, 1);
  endtask

  // Card side: idle cycles, then a reply; optional clear on the last bit.
  task automatic reply(input int dly, input logic [135:0] bits, input int len, input bit clr_last);
    for (int d = 0; d < dly; d++) begin
      cmd_line_in = 1'b1;
      chk("R12 busy while waiting", busy, 1);
      tick();
    end
    for (int i = 0; i < len; i++) begin
      cmd_line_in = bits[len-1-i];
      if (clr_last && i == len - 1) flag_clear = 4'hF;
      chk("R12 busy while receiving", busy, 1);
      tick();
    end
    flag_clear  = 4'h0;
    cmd_line_in = 1'b1;
  endtask

  function automatic logic [135:0] short_rsp(input logic [5:0] idx, input logic [31:0] st, input bit bad);
    logic [6:0] c;
    c = ref_crc({2'b00, idx, st});
    if (bad) c = c ^ 7'h01;
    return {88'd0, 2'b00, idx, st, c, 1'b1};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [47:0]  fr;
    logic [127:0] pay;
    rst_n = 1'b0; start = 1'b0; cmd_index = '0; cmd_arg = '0;
    arg_valid = 1'b0; rsp_expect = 1'b0; rsp_long = 1'b0;
    flag_clear = '0; cmd_line_in = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 enable", cmd_line_oe, 0);
    chk("R1 line", cmd_line_out, 1);
    chk("R1 flags", flags_now(), 0);
    chk("R1 words", {rsp_word0, rsp_word1, rsp_word2, rsp_word3}, 0);

    // R3, R4: no argument flagged, no response; known frame for index 0
    issue(6'd0, 32'hDEADBEEF, 1'b0, 1'b0, 1'b0, fr);
    chk("R3 zero argument frame", fr, 48'h400000000095);
    chk("R4 idle after frame", busy, 0);
    chk("R4 done only", flags_now(), 4'b0001);

    // R11 write-one-to-clear
    flag_clear = 4'b0001; tick(); flag_clear = 4'b0000;
    chk("R11 done cleared", flags_now(), 0);

    // R2, R6, R10, R11: short response, clear held on the completion edge
    issue(6'd8, 32'h000001AA, 1'b1, 1'b1, 1'b0, fr);
    chk("R2 known frame", fr, 48'h48000001AA87);
    chk("R5 waiting after frame", busy, 1);
    reply(2, short_rsp(6'd8, 32'h00000120, 1'b0), 48, 1'b1);
    chk("R12 idle after response", busy, 0);
    chk("R11 set beats clear", flags_now(), 4'b0101);
    chk("R6 status word", rsp_word0, 32'h00000120);
    chk("R6 upper words zero", {rsp_word1, rsp_word2, rsp_word3}, 0);

    // R8 bad CRC on a short response
    issue(6'd13, 32'h12340000, 1'b1, 1'b1, 1'b0, fr);
    reply(5, short_rsp(6'd13, 32'hCAFE0900, 1'b1), 48, 1'b0);
    chk("R8 crc error flagged", flags_now(), 4'b1101);
    chk("R8 word still captured", rsp_word0, 32'hCAFE0900);

    // R7 long response, reversed word order; R8 no CRC check on long
    pay = 128'h0123456789ABCDEF_F0E1D2C3B4A59687;
    issue(6'd2, 32'h0, 1'b1, 1'b1, 1'b1, fr);
    reply(3, {2'b00, 6'h3F, pay}, 136, 1'b0);
    chk("R7 word0", rsp_word0, pay[127:96]);
    chk("R7 word1", rsp_word1, pay[95:64]);
    chk("R7 word2", rsp_word2, pay[63:32]);
    chk("R7 word3", rsp_word3, pay[31:0]);
    chk("R8 long not crc checked", flags_now(), 4'b0101);
    flag_clear = 4'b0100; tick(); flag_clear = 4'b0000;
    chk("R11 partial clear", flags_now(), 4'b0001);

    // R9 long flag without response expected
    issue(6'd7, 32'h55AA55AA, 1'b1, 1'b0, 1'b1, fr);
    chk("R9 completes at once", busy, 0);
    chk("R9 done only", flags_now(), 4'b0001);
    cmd_line_in = 1'b0;
    repeat (3) tick();
    cmd_line_in = 1'b1;
    chk("R9 line ignored", busy, 0);
    chk("R9 words kept", rsp_word0, pay[127:96]);

    // R5 timeout after 64 high edges
    issue(6'd9, 32'h00010000, 1'b1, 1'b1, 1'b0, fr);
    reply(64, '0, 0, 1'b0);
    chk("R5 timeout ends busy", busy, 0);
    chk("R5 timeout flag only", flags_now(), 4'b0010);

    // R5 start bit on the 64th edge is accepted; R11 start wipes timeout
    issue(6'd3, 32'h0, 1'b0, 1'b1, 1'b0, fr);
    reply(63, short_rsp(6'd3, 32'hABCD0500, 1'b0), 48, 1'b0);
    chk("R5 late start accepted", flags_now(), 4'b0101);
    chk("R5 late word", rsp_word0, 32'hABCD0500);

    ended = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule